// File: doc/BRIEF.md
# GPIO Controller with Per-Line Interrupt Detection

This block is a sixteen-line general-purpose I/O peripheral on a simple 32-bit register bus. Software uses it to drive output values onto pads, to pick which lines are inputs, to read the pad levels, and to take interrupts from input lines. Each line has its own interrupt detector, and a 3-bit style code selects what the detector responds to: a high level, a low level, a rising edge, a falling edge, or any change. The style codes for eight lines are packed into each of two type registers. Bus writes take effect on a clock edge. Reads are combinational from the word index.

The pad inputs pass through a two-flop synchronizer. Edge styles compare the synchronized value with its value one clock earlier. Each line holds one status bit, and the status bits of the first thirteen lines drive active-high interrupt request outputs. A status bit is cleared by writing a one to it.

The status bit of each line is a two-state machine, `line_state_e`, with the states LN_IDLE and LN_PENDING:
- **detect**: LN_IDLE goes to LN_PENDING when the selected condition is seen.
- **clear**: LN_PENDING goes to LN_IDLE when a one is written to the line's status bit and no condition is seen in that cycle.
- In every other case the state holds.

A level style that still holds during a clear keeps the line in LN_PENDING.

The bus address is a word index, `bus_idx`, equal to the byte offset divided by four:

| Index | Register |
|-------|----------|
| 0 | Output data |
| 1 | Output enable |
| 2 | Input |
| 3 | Status |
| 4 | Type register for lines 0–7 |
| 5 | Type register for lines 8–15 |
| 6 | Clock control |
| 7 | Debounce select |

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the output-enable register reads 0x0000FFFF, so every line is an input and `pad_drive_en` is 0. The output data, status and both type registers read 0.
- R2: `pad_out` equals the output data register. `pad_drive_en[i]` is 1 exactly when output-enable bit i is 0, because a 1 in that register means input.
- R3: The input register (index 2) reads the pin value after two clocks. A pin change driven before clock edge n is visible after edge n+1 and not before it.
- R4: Style 0 (high level) and style 1 (low level) set the status bit on every clock edge at which the synchronized pin meets the level. A clear written while the level still holds leaves the bit set.
- R5: Style 2 (rising), style 3 (falling) and style 4 (any change) set the status bit when the synchronized value differs in the chosen direction from its value one clock earlier. The bit then stays set until it is cleared.
- R6: Writing a 1 to a status bit (index 3) clears it, and writing 0 leaves it unchanged. A detection in the same cycle as the clear wins, and the bit stays set.
- R7: The style of line i sits in bits 3i+2:3i of index 4 for lines 0–7. For lines 8–15 it sits at position 3(i−8) of index 5.
- R8: Style codes 5, 6 and 7 never set the status bit.
- R9: Bits 31:16 of the output data, output enable, input and status registers read 0. Bits 31:24 of both type registers read 0. Writes to those bits have no effect.
- R10: `irq_req[i]` equals status bit i for lines 0–12. Lines 13–15 set status bits, which can be read, but drive no request output.
- R11: The clock control register (index 6) and the debounce select register (index 7) store and read back all 32 bits, and both reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, together with bus_sel |
| bus_idx | input | 3 | Register word index (byte offset divided by four) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_idx, combinational |
| pin_in | input | 16 | Asynchronous pad input levels |
| pad_out | output | 16 | Output data driven to the pads |
| pad_drive_en | output | 16 | Pad driver enable per line, 1 drives the pad |
| irq_req | output | 13 | Active-high interrupt requests for lines 0–12 |

## Verification
The bench builds the block with its default parameters: sixteen lines, thirteen request outputs, 3-bit styles and eight lines per type register. These values bring both type registers into use, including the index offset that lines 8–15 take in the second one. They also bring in the three upper lines, whose status bits can be read but which have no request output. A behavioural model runs beside the design and checks every output on every cycle. Directed sequences then cover all eight style codes, clears written while a level holds, a clear timed into the same cycle as a rising edge, and writes to the reserved bits.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int IDX_W = 3;

    localparam logic [IDX_W-1:0] IDX_DOUT  = 3'd0;
    localparam logic [IDX_W-1:0] IDX_OE    = 3'd1;
    localparam logic [IDX_W-1:0] IDX_DIN   = 3'd2;
    localparam logic [IDX_W-1:0] IDX_STAT  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_TYPE0 = 3'd4;
    localparam logic [IDX_W-1:0] IDX_TYPE1 = 3'd5;
    localparam logic [IDX_W-1:0] IDX_CLK   = 3'd6;
    localparam logic [IDX_W-1:0] IDX_DBS   = 3'd7;

    typedef enum logic [2:0] {
        STY_LVL_HI = 3'd0,
        STY_LVL_LO = 3'd1,
        STY_RISE   = 3'd2,
        STY_FALL   = 3'd3,
        STY_ANY    = 3'd4
    } style_e;

    typedef enum logic {
        LN_IDLE    = 1'b0,
        LN_PENDING = 1'b1
    } line_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] pin_in,
    output logic [N_LINES-1:0] sync_q,
    output logic [N_LINES-1:0] prev_q
);

    logic [N_LINES-1:0] stage1_q;

    // Two synchronizer flops, then one more register that holds
    // the previous synchronized value for the edge detectors.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            sync_q   <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= pin_in;
            sync_q   <= stage1_q;
            prev_q   <= sync_q;
        end
    end

endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
    import gpio_irq_pkg::*;
#(
    parameter int STYLE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_in,
    input  logic               sync_prev,
    input  logic [STYLE_W-1:0] style,
    input  logic               clr,
    output logic               pending
);

    line_state_e state_q;
    line_state_e state_d;
    logic        det;

    // Condition selected by the style code. Codes above 4 detect nothing.
    always_comb begin
        case (style)
            STY_LVL_HI: det = sync_in;
            STY_LVL_LO: det = !sync_in;
            STY_RISE:   det = sync_in && !sync_prev;
            STY_FALL:   det = !sync_in && sync_prev;
            STY_ANY:    det = sync_in ^ sync_prev;
            default:    det = 1'b0;
        endcase
    end

    // Next-state logic. A detection outranks a clear in the same cycle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE:    if (det) state_d = LN_PENDING;
            LN_PENDING: if (clr && !det) state_d = LN_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_IDLE;
        else        state_q <= state_d;
    end

    // Output process.
    always_comb begin
        pending = (state_q == LN_PENDING);
    end

    // R4: a level condition that holds sets the line on the next edge.
    assert_level_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((style == STY_LVL_HI && sync_in) || (style == STY_LVL_LO && !sync_in))
        |=> pending);

    // R5: a set line with no clear stays set.
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clr) |=> pending);

    // R6: a clear under a non-detecting code empties the line.
    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && style >= 3'd5) |=> !pending);

    // R8: codes 5 to 7 never raise the line.
    assert_nodetect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && style >= 3'd5) |=> !pending);

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_irq_pkg::*;
#(
    parameter int N_LINES       = 16,
    parameter int STYLE_W       = 3,
    parameter int LINES_PER_REG = 8,
    parameter int REG_W         = 32,
    localparam int TYPE_W       = LINES_PER_REG * STYLE_W,
    localparam int N_TREG       = (N_LINES + LINES_PER_REG - 1) / LINES_PER_REG
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         idx,
    input  logic [REG_W-1:0]         wdata,
    input  logic [N_LINES-1:0]       sync_in,
    input  logic [N_LINES-1:0]       status,
    output logic [REG_W-1:0]         rdata,
    output logic [N_LINES-1:0]       dout_q,
    output logic [N_LINES-1:0]       oe_q,
    output logic [N_TREG*TYPE_W-1:0] style_flat,
    output logic [N_LINES-1:0]       clr_mask
);

    logic [TYPE_W-1:0] type_q [N_TREG];
    logic [REG_W-1:0]  clkc_q;
    logic [REG_W-1:0]  dbs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            oe_q   <= '1;
            clkc_q <= '0;
            dbs_q  <= '0;
        end else if (wr_en) begin
            case (idx)
                IDX_DOUT: dout_q <= wdata[N_LINES-1:0];
                IDX_OE:   oe_q   <= wdata[N_LINES-1:0];
                IDX_CLK:  clkc_q <= wdata;
                IDX_DBS:  dbs_q  <= wdata;
                default:  ;
            endcase
        end
    end

    // One type register per group of lines; only the style bits are stored.
    for (genvar k = 0; k < N_TREG; k++) begin : g_type
        localparam logic [IDX_W-1:0] KIDX = IDX_TYPE0 + IDX_W'(k);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     type_q[k] <= '0;
            else if (wr_en && idx == KIDX)  type_q[k] <= wdata[TYPE_W-1:0];
        end
        assign style_flat[k*TYPE_W +: TYPE_W] = type_q[k];
    end

    assign clr_mask = (wr_en && idx == IDX_STAT) ? wdata[N_LINES-1:0] : '0;

    always_comb begin
        rdata = '0;
        case (idx)
            IDX_DOUT: rdata[N_LINES-1:0] = dout_q;
            IDX_OE:   rdata[N_LINES-1:0] = oe_q;
            IDX_DIN:  rdata[N_LINES-1:0] = sync_in;
            IDX_STAT: rdata[N_LINES-1:0] = status;
            IDX_CLK:  rdata = clkc_q;
            IDX_DBS:  rdata = dbs_q;
            default:  ;
        endcase
        for (int k = 0; k < N_TREG; k++) begin
            if (idx == IDX_TYPE0 + IDX_W'(k)) rdata[TYPE_W-1:0] = type_q[k];
        end
    end

    // R9: the unused top bits of a type register always read zero.
    assert_type_resv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == IDX_TYPE0 || idx == IDX_TYPE1) |-> (rdata[REG_W-1:TYPE_W] == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int N_LINES       = 16,
    parameter int N_IRQ         = 13,
    parameter int STYLE_W       = 3,
    parameter int LINES_PER_REG = 8,
    parameter int REG_W         = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [IDX_W-1:0]   bus_idx,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [N_LINES-1:0] pin_in,
    output logic [N_LINES-1:0] pad_out,
    output logic [N_LINES-1:0] pad_drive_en,
    output logic [N_IRQ-1:0]   irq_req
);

    localparam int TYPE_W = LINES_PER_REG * STYLE_W;
    localparam int N_TREG = (N_LINES + LINES_PER_REG - 1) / LINES_PER_REG;

    logic [N_LINES-1:0]       sync_q;
    logic [N_LINES-1:0]       prev_q;
    logic [N_LINES-1:0]       status;
    logic [N_LINES-1:0]       clr_mask;
    logic [N_LINES-1:0]       dout_q;
    logic [N_LINES-1:0]       oe_q;
    logic [N_TREG*TYPE_W-1:0] style_flat;

    gpio_sync #(.N_LINES(N_LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .sync_q (sync_q),
        .prev_q (prev_q)
    );

    gpio_regfile #(
        .N_LINES       (N_LINES),
        .STYLE_W       (STYLE_W),
        .LINES_PER_REG (LINES_PER_REG),
        .REG_W         (REG_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_sel && bus_wr),
        .idx        (bus_idx),
        .wdata      (bus_wdata),
        .sync_in    (sync_q),
        .status     (status),
        .rdata      (bus_rdata),
        .dout_q     (dout_q),
        .oe_q       (oe_q),
        .style_flat (style_flat),
        .clr_mask   (clr_mask)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        gpio_line_detect #(.STYLE_W(STYLE_W)) u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_in   (sync_q[i]),
            .sync_prev (prev_q[i]),
            .style     (style_flat[i*STYLE_W +: STYLE_W]),
            .clr       (clr_mask[i]),
            .pending   (status[i])
        );
    end

    assign pad_out      = dout_q;
    assign pad_drive_en = ~oe_q;
    assign irq_req      = status[N_IRQ-1:0];

endmodule

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/100ps
module gpio_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_idx = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = 16'd0;
    logic [15:0] pad_out;
    logic [15:0] pad_drive_en;
    logic [12:0] irq_req;

    int n_checks = 0;
    int n_errs   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pad_out(pad_out), .pad_drive_en(pad_drive_en),
        .irq_req(irq_req)
    );

    // Behavioural reference model
    logic [15:0] m_s1 = 0, m_s2 = 0, m_prev = 0;
    logic [15:0] m_dout = 0, m_oe = 16'hFFFF, m_stat = 0;
    logic [23:0] m_type0 = 0, m_type1 = 0;
    logic [31:0] m_clk = 0, m_dbs = 0;

    function automatic logic [31:0] m_read(input logic [2:0] idx);
        case (idx)
            3'd0: return {16'd0, m_dout};
            3'd1: return {16'd0, m_oe};
            3'd2: return {16'd0, m_s2};
            3'd3: return {16'd0, m_stat};
            3'd4: return {8'd0, m_type0};
            3'd5: return {8'd0, m_type1};
            3'd6: return m_clk;
            default: return m_dbs;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_dout = 0; m_oe = 16'hFFFF;
            m_stat = 0; m_type0 = 0; m_type1 = 0; m_clk = 0; m_dbs = 0;
        end else begin
            logic [15:0] det;
            logic [15:0] clr;
            for (int i = 0; i < 16; i++) begin
                int code;
                code = (i < 8) ? int'(m_type0[i*3 +: 3]) : int'(m_type1[(i-8)*3 +: 3]);
                case (code)
                    0: det[i] = m_s2[i];
                    1: det[i] = !m_s2[i];
                    2: det[i] = m_s2[i] && !m_prev[i];
                    3: det[i] = !m_s2[i] && m_prev[i];
                    4: det[i] = m_s2[i] != m_prev[i];
                    default: det[i] = 1'b0;
                endcase
            end
            clr = (bus_sel && bus_wr && bus_idx == 3'd3) ? bus_wdata[15:0] : 16'd0;
            m_stat = (m_stat & ~clr) | det;
            if (bus_sel && bus_wr) begin
                case (bus_idx)
                    3'd0: m_dout  = bus_wdata[15:0];
                    3'd1: m_oe    = bus_wdata[15:0];
                    3'd4: m_type0 = bus_wdata[23:0];
                    3'd5: m_type1 = bus_wdata[23:0];
                    3'd6: m_clk   = bus_wdata;
                    3'd7: m_dbs   = bus_wdata;
                    default: ;
                endcase
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model comparison every cycle, before inputs move (inputs change at negedge+1)
    always @(negedge clk) begin
        cycles++;
        check("R10 irq_req vs model", {19'd0, irq_req}, {19'd0, m_stat[12:0]});
        check("R2 pad_out vs model", {16'd0, pad_out}, {16'd0, m_dout});
        check("R2 pad_drive_en vs model", {16'd0, pad_drive_en}, {16'd0, ~m_oe});
        check("R9 bus_rdata vs model", bus_rdata, m_read(bus_idx));
        if (cycles > 50000) begin
            n_errs++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] idx, input logic [31:0] data);
        @(negedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_idx = idx; bus_wdata = data;
        @(negedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] idx, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_idx = idx;
        @(negedge clk);
        check(tag, bus_rdata, exp);
        #1 bus_sel = 0;
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk); #1 pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rd(3'd1, 32'h0000FFFF, "R1 oe reset");
        rd(3'd0, 32'h0, "R1 dout reset");
        rd(3'd3, 32'h0, "R1 status reset");
        rd(3'd4, 32'h0, "R1 type0 reset");
        check("R1 drive_en reset", {16'd0, pad_drive_en}, 32'h0);

        // R2 and R9 output data and direction
        wr(3'd0, 32'hFFFFA5C3);
        wr(3'd1, 32'hFFFF0F0F);
        @(negedge clk);
        check("R2 pad_out", {16'd0, pad_out}, 32'h0000A5C3);
        check("R2 drive_en inverted", {16'd0, pad_drive_en}, 32'h0000F0F0);
        rd(3'd0, 32'h0000A5C3, "R9 dout upper bits");
        rd(3'd1, 32'h00000F0F, "R9 oe upper bits");

        // R3 two-flop latency on the input register
        @(negedge clk); #1 bus_idx = 3'd2; pin_in = 16'h1234;
        @(negedge clk);
        check("R3 input after one edge", bus_rdata, 32'h0);
        @(negedge clk);
        check("R3 input after two edges", bus_rdata, 32'h00001234);
        set_pins(16'h0000);
        wr(3'd3, 32'h0000FFFF);
        rd(3'd3, 32'h0, "R6 clear all");

        // R7, R8, R9 style placement and reserved bits
        wr(3'd4, 32'hFFFA911A);
        rd(3'd4, 32'h00FA911A, "R9 type0 upper bits");
        wr(3'd5, 32'h00010010);
        rd(3'd5, 32'h00010010, "R7 type1 readback");
        wr(3'd3, 32'h0000FFFF);
        rd(3'd3, 32'h00000010, "R4 level low survives clear");

        // R5, R7, R8, R10 rising edges
        set_pins(16'h22E7);
        rd(3'd3, 32'h00002215, "R5 R7 R8 rising detect");
        @(negedge clk);
        check("R10 irq lines 0-12", {19'd0, irq_req}, 32'h00000215);

        // R6 write zero keeps bits, write one clears
        wr(3'd3, 32'h0);
        rd(3'd3, 32'h00002215, "R6 write zero no effect");
        wr(3'd3, 32'h00000004);
        rd(3'd3, 32'h00002211, "R6 write one clears");

        // R5 falling and any-change, sticky line 0
        set_pins(16'h2200);
        rd(3'd3, 32'h00002217, "R5 falling and sticky");

        // R4 level high held through clear, then released
        set_pins(16'h2208);
        wr(3'd3, 32'h00000008);
        rd(3'd3, 32'h0000221F, "R4 level high held");
        set_pins(16'h2200);
        wr(3'd3, 32'h00000008);
        rd(3'd3, 32'h00002217, "R4 level cleared after release");

        // R6 edge wins over a clear in the same cycle
        wr(3'd3, 32'h00000001);
        rd(3'd3, 32'h00002216, "R6 line0 cleared");
        @(negedge clk); #1 pin_in = 16'h2201;
        @(negedge clk);
        @(negedge clk); #1 bus_sel = 1; bus_wr = 1; bus_idx = 3'd3; bus_wdata = 32'h1;
        @(negedge clk); #1 bus_sel = 0; bus_wr = 0;
        rd(3'd3, 32'h00002217, "R6 edge beats clear");

        // R11 plain registers
        wr(3'd6, 32'hDEADBEEF);
        rd(3'd6, 32'hDEADBEEF, "R11 clock control");
        wr(3'd7, 32'h12345678);
        rd(3'd7, 32'h12345678, "R11 debounce select");

        repeat (3) @(negedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule